// File: doc/BRIEF.md
# Keyed-Restart Watchdog Timer

This block is a memory-mapped watchdog for a processor subsystem. Once software turns it on, a free-running divide-by-32 prescaler feeds a main counter. The main counter expires after a power-of-two number of prescaled ticks, and the exponent is fixed by a configuration field. On expiry the block raises a one-cycle reset request toward the system reset controller. It also records the event in a sticky status flag that software can inspect and later clear.

Software keeps the system alive by writing a 16-bit key as a halfword into the upper half of the control word. Any other value, width or address is ignored. The enable bit can be updated through the plain control address or through set and clear alias addresses, which give atomic single-bit updates. The clock-source select, postscaler exponent and windowed-clear indication are read-only. They are captured from configuration inputs while reset is held. When the enable bit falls, the register port is deaf for one cycle.

Top module: `keyed_wdt`

## Requirements
- R1: After reset the timer is off, the sticky flag is clear, the reset request is low, and reading the status word (byte address 0x10) returns 0.
- R2: The postscaler exponent (control bits 12:8) and the clock-source select (control bits 7:6) read back the values present on the configuration inputs during reset. Later changes on those inputs, and software writes to those bits, have no effect.
- R3: Control bit 15 is the enable. A write to address 0x00 with byte lane 1 enabled loads it from data bit 15. A one in data bit 15 written to address 0x04 sets it, and written to 0x08 clears it, in both cases only when byte lane 1 is enabled.
- R4: While enabled, the reset request goes high for exactly one cycle 32 × 2^P clock cycles after the enabling or restarting write, where P is the postscaler exponent. The count then starts over from zero, so pulses repeat with that period.
- R5: A write to address 0x00 with byte enables 4'b1100 and data bits 31:16 equal to 16'h5743 restarts the count from zero.
- R6: The following writes do not restart the count: a wrong key value, the key written through an alias address, the key inside a full-word write, and the key with only one of the two upper byte lanes enabled.
- R7: Status bit 4 is set on every expiry. It stays set until a one in data bit 4 is written to address 0x18 with byte lane 0 enabled. Writes to address 0x10 do not change it. If an expiry and a clear happen in the same cycle, the expiry wins. Status bits 2 and 3 read as zero.
- R8: While the enable is 0, the counter is held at zero and no reset request is raised. Re-enabling starts a full period.
- R9: In the one cycle after the enable bit goes from 1 to 0, writes are dropped and reads return zero.
- R10: Control bit 0 reads back the windowed-clear configuration input captured during reset, and software cannot write it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; configuration inputs are sampled while it is low |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_be | input | 4 | Byte-lane enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address; zero when not reading |
| cfg_window | input | 1 | Windowed-clear configuration |
| cfg_clksel | input | 2 | Clock-source select configuration |
| cfg_postscale | input | 5 | Postscaler exponent P |
| wdt_reset_req | output | 1 | One-cycle reset request on expiry |

## Verification
The bench times the expiry pulse to the exact cycle and watches for any early pulse. A design with an off-by-one in the prescaler, or with a counter compare against 2^P−1, would pulse one cycle early or 32 cycles early. Near-miss keys are written mid-period: a wrong value, alias addresses, a full-word write and a partial lane set. A decoder that is too loose would move the pulse late. The busy cycle after disabling is hit with a back-to-back enable write and with a read. A design without the window would re-enable, or would return the control word. The sticky flag is checked after the timer is stopped and after a write to its plain address, which would expose a flag that is level-driven or cleared from the wrong address.

// File: rtl/keyed_wdt_pkg.sv
package keyed_wdt_pkg;
  localparam int DATA_W = 32;
  localparam int BE_W   = 4;
  localparam int PS_W   = 5;
  localparam int CS_W   = 2;

  localparam logic [15:0] RESTART_KEY = 16'h5743;
  localparam logic [BE_W-1:0] KEY_LANES = 4'b1100;

  localparam logic [7:0] OFF_CTRL     = 8'h00;
  localparam logic [7:0] OFF_CTRL_SET = 8'h04;
  localparam logic [7:0] OFF_CTRL_CLR = 8'h08;
  localparam logic [7:0] OFF_STAT     = 8'h10;
  localparam logic [7:0] OFF_STAT_CLR = 8'h18;

  localparam int WIN_BIT  = 0;
  localparam int CS_LSB   = 6;
  localparam int PS_LSB   = 8;
  localparam int ON_BIT   = 15;
  localparam int FLAG_BIT = 4;

  localparam logic [DATA_W-1:0] ON_MASK   = 32'h1 << ON_BIT;
  localparam logic [DATA_W-1:0] FLAG_MASK = 32'h1 << FLAG_BIT;

  function automatic logic [DATA_W-1:0] pack_ctrl(input logic on,
                                                  input logic [CS_W-1:0] cs,
                                                  input logic [PS_W-1:0] ps,
                                                  input logic win);
    logic [DATA_W-1:0] w;
    w = '0;
    w[ON_BIT] = on;
    w[CS_LSB +: CS_W] = cs;
    w[PS_LSB +: PS_W] = ps;
    w[WIN_BIT] = win;
    return w;
  endfunction

  function automatic logic [DATA_W-1:0] pack_stat(input logic flag);
    logic [DATA_W-1:0] w;
    w = '0;
    w[FLAG_BIT] = flag;
    return w;
  endfunction
endpackage

// File: rtl/wdt_counter.sv
module wdt_counter
  import keyed_wdt_pkg::*;
#(
  parameter int PRE_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            on,
  input  logic            restart,
  input  logic [PS_W-1:0] ps,
  output logic            expire,
  output logic            req
);
  localparam int CNT_W = (1 << PS_W) + 1;

  function automatic logic [CNT_W-1:0] terminal_of(input logic [PS_W-1:0] p);
    return CNT_W'(1) << p;
  endfunction

  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_inc;
  logic             tick;

  assign tick    = on && (pre_q == '1);
  assign cnt_inc = cnt_q + CNT_W'(1);
  assign expire  = tick && !restart && (cnt_inc == terminal_of(ps));

  always_ff @(posedge clk) begin
    if (!rst_n || !on || restart) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else begin
      pre_q <= pre_q + PRE_W'(1);
      if (tick) cnt_q <= expire ? '0 : cnt_inc;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) req <= 1'b0;
    else        req <= expire;
  end

  assert_req_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> !req);

  assert_off_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !on |=> !req);
endmodule

// File: rtl/wdt_regfile.sv
module wdt_regfile
  import keyed_wdt_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BE_W-1:0]   bus_be,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              cfg_window,
  input  logic [CS_W-1:0]   cfg_clksel,
  input  logic [PS_W-1:0]   cfg_postscale,
  input  logic              expire,
  output logic              on,
  output logic              restart,
  output logic [PS_W-1:0]   ps
);
  logic            win_q;
  logic [CS_W-1:0] cs_q;
  logic [PS_W-1:0] ps_q;
  logic            on_q, on_next, busy_q, flag_q;
  logic            wr, rd, data_on, data_flag;
  logic            hit_ctrl, hit_set, hit_clr, hit_stat, hit_sclr;

  assign hit_ctrl = bus_addr == ADDR_W'(OFF_CTRL);
  assign hit_set  = bus_addr == ADDR_W'(OFF_CTRL_SET);
  assign hit_clr  = bus_addr == ADDR_W'(OFF_CTRL_CLR);
  assign hit_stat = bus_addr == ADDR_W'(OFF_STAT);
  assign hit_sclr = bus_addr == ADDR_W'(OFF_STAT_CLR);

  assign wr        = bus_valid && bus_write && !busy_q;
  assign rd        = bus_valid && !bus_write && !busy_q;
  assign data_on   = |(bus_wdata & ON_MASK);
  assign data_flag = |(bus_wdata & FLAG_MASK);
  assign restart   = wr && hit_ctrl && (bus_be == KEY_LANES)
                     && (bus_wdata[31:16] == RESTART_KEY);

  always_comb begin
    on_next = on_q;
    if (wr && bus_be[1]) begin
      if (hit_ctrl)               on_next = data_on;
      else if (hit_set && data_on) on_next = 1'b1;
      else if (hit_clr && data_on) on_next = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_q <= cfg_window;
      cs_q  <= cfg_clksel;
      ps_q  <= cfg_postscale;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      on_q   <= 1'b0;
      busy_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      on_q   <= on_next;
      busy_q <= on_q && !on_next;
      if (expire) flag_q <= 1'b1;
      else if (wr && hit_sclr && bus_be[0] && data_flag) flag_q <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd) begin
      if (hit_ctrl || hit_set || hit_clr) bus_rdata = pack_ctrl(on_q, cs_q, ps_q, win_q);
      else if (hit_stat || hit_sclr)      bus_rdata = pack_stat(flag_q);
    end
  end

  assign on = on_q;
  assign ps = ps_q;

  assert_flag_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> flag_q);

  assert_busy_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && bus_valid && bus_write) |=> (on_q == $past(on_q)));

  assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |=> $stable({win_q, cs_q, ps_q}));
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
  import keyed_wdt_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int PRE_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BE_W-1:0]   bus_be,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              cfg_window,
  input  logic [CS_W-1:0]   cfg_clksel,
  input  logic [PS_W-1:0]   cfg_postscale,
  output logic              wdt_reset_req
);
  logic            on_w, restart_w, expire_w;
  logic [PS_W-1:0] ps_w;

  wdt_regfile #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cfg_window(cfg_window), .cfg_clksel(cfg_clksel), .cfg_postscale(cfg_postscale),
    .expire(expire_w), .on(on_w), .restart(restart_w), .ps(ps_w)
  );

  wdt_counter #(.PRE_W(PRE_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .on(on_w), .restart(restart_w), .ps(ps_w),
    .expire(expire_w), .req(wdt_reset_req)
  );
endmodule

// File: tb/tb_keyed_wdt.sv
`timescale 1ns/1ps
module tb_keyed_wdt;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        cfg_window = 1'b1;
  logic [1:0]  cfg_clksel = 2'b10;
  logic [4:0]  cfg_postscale = 5'd2;
  logic        wdt_reset_req;

  int n_checks = 0, n_fail = 0;
  localparam int PERIOD = 32 * (1 << 2);
  localparam logic [31:0] CTRL_OFF = 32'h0000_0281;
  localparam logic [31:0] CTRL_ON  = 32'h0000_8281;

  always #2.5 clk = ~clk;

  keyed_wdt dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [3:0] be, input logic [31:0] d);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_be = be; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_valid = 1; bus_write = 0; bus_addr = a; bus_be = 4'hF;
    #1 d = bus_rdata;
    @(posedge clk); @(negedge clk);
    bus_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // pulse expected at the k-th edge after the current negedge
  task automatic expect_pulse(input string tag, input int k);
    logic early = 1'b0;
    for (int i = 1; i < k; i++) begin
      @(negedge clk);
      if (wdt_reset_req) early = 1'b1;
    end
    chk({tag, " no early pulse"}, {31'b0, early}, 32'h0);
    @(negedge clk); chk({tag, " pulse high"}, {31'b0, wdt_reset_req}, 32'h1);
    @(negedge clk); chk({tag, " pulse one cycle"}, {31'b0, wdt_reset_req}, 32'h0);
  endtask

  task automatic stop_timer();
    wr(5'h08, 4'hF, 32'h8000);
    idle(1);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 req low", {31'b0, wdt_reset_req}, 32'h0);
    rd(5'h00, d); chk("R1/R10 ctrl after reset", d, CTRL_OFF);
    rd(5'h10, d); chk("R1 status after reset", d, 32'h0);
  endtask

  task automatic t_cfg();
    logic [31:0] d;
    cfg_window = 0; cfg_clksel = 2'b01; cfg_postscale = 5'd9;
    rd(5'h00, d); chk("R2 cfg inputs ignored after reset", d, CTRL_OFF);
    wr(5'h00, 4'hF, 32'hFFFF_FFFF);
    rd(5'h00, d); chk("R2/R10 read-only fields survive write", d, CTRL_ON);
    stop_timer();
    rd(5'h00, d); chk("R2 stopped", d, CTRL_OFF);
  endtask

  task automatic t_onoff();
    logic [31:0] d;
    wr(5'h04, 4'h1, 32'h8000);
    rd(5'h00, d); chk("R3 set alias needs lane 1", d, CTRL_OFF);
    wr(5'h04, 4'h2, 32'h8000);
    rd(5'h00, d); chk("R3 set alias", d, CTRL_ON);
    wr(5'h00, 4'h3, 32'h0);
    idle(1);
    rd(5'h00, d); chk("R3 plain write clears", d, CTRL_OFF);
    wr(5'h00, 4'h3, 32'h8000);
    rd(5'h00, d); chk("R3 plain write sets", d, CTRL_ON);
    wr(5'h08, 4'h2, 32'h8000);
    idle(1);
    rd(5'h00, d); chk("R3 clear alias", d, CTRL_OFF);
  endtask

  task automatic t_timeout();
    logic [31:0] d;
    wr(5'h04, 4'hF, 32'h8000);
    expect_pulse("R4 first expiry", PERIOD);
    expect_pulse("R4 periodic expiry", PERIOD - 1);
    stop_timer();
    rd(5'h10, d); chk("R7 flag set", d, 32'h10);
  endtask

  task automatic t_sticky();
    logic [31:0] d;
    idle(20);
    rd(5'h10, d); chk("R7 flag sticky", d, 32'h10);
    wr(5'h10, 4'hF, 32'hFFFF_FFFF);
    rd(5'h10, d); chk("R7 plain status write ignored", d, 32'h10);
    wr(5'h18, 4'h1, 32'h10);
    rd(5'h10, d); chk("R7 clear alias", d, 32'h0);
  endtask

  task automatic t_key();
    wr(5'h04, 4'hF, 32'h8000);
    idle(59);
    wr(5'h00, 4'hC, 32'h5743_0000);
    expect_pulse("R5 key restart", PERIOD);
    stop_timer();
  endtask

  task automatic t_badkey();
    wr(5'h04, 4'hF, 32'h8000);
    idle(9); wr(5'h00, 4'hC, 32'h5744_0000);
    idle(9); wr(5'h04, 4'hC, 32'h5743_0000);
    idle(9); wr(5'h00, 4'hF, 32'h5743_8000);
    idle(9); wr(5'h00, 4'h4, 32'h5743_0000);
    expect_pulse("R6 near-miss keys ignored", PERIOD - 40);
    stop_timer();
  endtask

  task automatic t_off();
    logic seen = 1'b0;
    for (int i = 0; i < 3 * PERIOD; i++) begin
      @(negedge clk);
      if (wdt_reset_req) seen = 1'b1;
    end
    chk("R8 no request while off", {31'b0, seen}, 32'h0);
    wr(5'h04, 4'hF, 32'h8000);
    idle(99);
    stop_timer();
    idle(5);
    wr(5'h04, 4'hF, 32'h8000);
    expect_pulse("R8 full period after re-enable", PERIOD);
    stop_timer();
  endtask

  task automatic t_busy();
    logic [31:0] d;
    wr(5'h04, 4'hF, 32'h8000);
    wr(5'h08, 4'hF, 32'h8000);
    wr(5'h04, 4'hF, 32'h8000);
    rd(5'h00, d); chk("R9 write in busy cycle dropped", d, CTRL_OFF);
    wr(5'h04, 4'hF, 32'h8000);
    wr(5'h08, 4'hF, 32'h8000);
    rd(5'h00, d); chk("R9 read in busy cycle is zero", d, 32'h0);
    wr(5'h04, 4'hF, 32'h8000);
    rd(5'h00, d); chk("R9 access accepted after busy", d, CTRL_ON);
    stop_timer();
  endtask

  initial begin
    #(200000 * 5);
    n_fail++; n_checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_cfg();
    t_onoff();
    t_timeout();
    t_sticky();
    t_key();
    t_badkey();
    t_off();
    t_busy();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule